// File: doc/BRIEF.md
# Counting Interrupt Acknowledge Register

This block tracks completion interrupts for a multi-channel DMA engine. Each channel owns one 32-bit register. It holds a six-bit completion counter and a six-bit acknowledge field. When the engine finishes a transfer on a channel, it pulses that channel's strobe for one cycle. The counter then steps up by one, and the channel's interrupt line rises.

Firmware finds the channel that needs service by reading the counters. It then writes the count it saw back into the acknowledge field. A channel's interrupt stays pending as long as its counter and its acknowledge value differ. If a transfer completes while firmware is servicing the channel, the counter moves past the value firmware wrote. The interrupt therefore stays up, and the completion is not lost.

The channel registers sit 4 bytes apart, starting at a base byte offset. Reads return their data one cycle after the request. A combined interrupt output is the OR of all the channel lines.

Top module: `irq_ack_tracker`

## Requirements
- R1: After reset, every counter and acknowledge field is zero, every channel interrupt and the combined interrupt are low, and the read data is zero.
- R2: A read of channel i uses byte address BASE+4*i. One cycle after the request, the read data carries the counter in bits 29:24 and the acknowledge value in bits 5:0. In a cycle after no read, or after a read of an address that matches no channel, the read data is zero.
- R3: Bits 31:30 and 23:6 of the read data are always zero, and write data in those bits changes nothing.
- R4: A one-cycle completion strobe increments that channel's counter by exactly one and raises its interrupt on the following clock edge.
- R5: The counter only counts up. After 63 it wraps to 0.
- R6: A channel interrupt is high exactly when its counter differs from its acknowledge field. Writing the current count clears the interrupt on the next edge. Writing a stale count leaves it high.
- R7: When a strobe and an acknowledge write reach the same channel in the same cycle, the counter still increments. The interrupt is then decided by comparing the new count with the written value.
- R8: Write data in bits 29:24 never changes the counter.
- R9: The combined interrupt is high exactly when at least one channel interrupt is high. It changes on the same edge as the channel lines.
- R10: A write to a misaligned address, an address below BASE, or an address past the last channel changes no channel.
- R11: Channels are independent. A strobe or a write on one channel leaves the other channels' counters, acknowledge fields and interrupts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write request |
| reg_rd_en | input | 1 | Register read request |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | 32 | Write data; only bits 5:0 are used |
| reg_rdata | output | 32 | Read data, valid one cycle after the request |
| done_strobe | input | N_CH | One-cycle transfer-complete pulse per channel |
| chan_irq | output | N_CH | Registered per-channel pending interrupt |
| any_irq | output | 1 | Registered OR of all channel interrupts |

## Verification
The bench drives a strobe and an acknowledge write into the same channel in the same cycle. A design that compares against the old count would drop the interrupt there and lose the completion. It writes a stale count, which a clear-on-any-write design would wrongly accept. It also sets every bit of the counter field in the write data, which exposes a counter that software can write.

Sixty-four strobes without any acknowledge test the wrap. The 64th strobe must bring the count back to zero, which again equals the acknowledge value. A saturating counter would get this wrong, and so would a counter with a stuck interrupt.

Writes to a misaligned address, to an address below BASE, and to the address just past the last channel must leave every acknowledge field unchanged. This catches a loose address decode.

// File: rtl/irqack_pkg.sv
package irqack_pkg;
    localparam int DATA_W  = 32;
    localparam int FLD_W   = 6;
    localparam int CNT_LSB = 24;
    localparam int ACK_LSB = 0;

    typedef logic [FLD_W-1:0] fld_t;

    typedef struct packed {
        fld_t cnt;
        fld_t ack;
        logic pend;
    } chan_st_t;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              any;
    } top_st_t;

    function automatic logic [DATA_W-1:0] pack_word(input fld_t c, input fld_t a);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CNT_LSB +: FLD_W] = c;
        w[ACK_LSB +: FLD_W] = a;
        return w;
    endfunction
endpackage

// File: rtl/irqack_decode.sv
module irqack_decode #(
    parameter int N_CH   = 4,
    parameter int ADDR_W = 8,
    parameter int BASE   = 64
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [N_CH-1:0]   sel,
    output logic              hit
);
    localparam int STRIDE = 4;

    for (genvar i = 0; i < N_CH; i++) begin : g_sel
        localparam logic [ADDR_W-1:0] CH_ADDR = ADDR_W'(BASE + STRIDE * i);
        assign sel[i] = (addr == CH_ADDR);
    end

    assign hit = |sel;
endmodule

// File: rtl/irqack_channel.sv
module irqack_channel
    import irqack_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic wr,
    input  fld_t wr_ack,
    output fld_t cnt_q,
    output fld_t ack_q,
    output logic pend_q,
    output logic pend_nxt
);
    chan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (inc) begin
            st_d.cnt = st_q.cnt + FLD_W'(1);
        end
        if (wr) begin
            st_d.ack = wr_ack;
        end
        // compare against the post-increment count so same-cycle completions stay pending
        st_d.pend = (st_d.cnt != st_d.ack);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q    = st_q.cnt;
    assign ack_q    = st_q.ack;
    assign pend_q   = st_q.pend;
    assign pend_nxt = st_d.pend;
endmodule

// File: rtl/irqack_readmux.sv
module irqack_readmux
    import irqack_pkg::*;
#(
    parameter int N_CH = 4
) (
    input  logic [N_CH-1:0]        sel,
    input  fld_t [N_CH-1:0]        cnt_v,
    input  fld_t [N_CH-1:0]        ack_v,
    output logic [DATA_W-1:0]      word
);
    always_comb begin
        word = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (sel[i]) begin
                word = word | pack_word(cnt_v[i], ack_v[i]);
            end
        end
    end
endmodule

// File: rtl/irq_ack_tracker.sv
module irq_ack_tracker
    import irqack_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int ADDR_W = 8,
    parameter int BASE   = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr_en,
    input  logic                 reg_rd_en,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic [N_CH-1:0]      done_strobe,
    output logic [N_CH-1:0]      chan_irq,
    output logic                 any_irq
);
    logic [N_CH-1:0] sel;
    logic            hit;
    fld_t [N_CH-1:0] cnt_v;
    fld_t [N_CH-1:0] ack_v;
    logic [N_CH-1:0] pend_nxt;
    logic [31:0]     rd_word;
    fld_t            wr_ack;
    logic            unused_wbits;

    top_st_t top_d, top_q;

    assign wr_ack       = reg_wdata[ACK_LSB +: FLD_W];
    assign unused_wbits = ^{reg_wdata[31:ACK_LSB+FLD_W], hit};

    irqack_decode #(
        .N_CH   (N_CH),
        .ADDR_W (ADDR_W),
        .BASE   (BASE)
    ) u_decode (
        .addr (reg_addr),
        .sel  (sel),
        .hit  (hit)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_chan
        irqack_channel u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .inc      (done_strobe[i]),
            .wr       (reg_wr_en && sel[i]),
            .wr_ack   (wr_ack),
            .cnt_q    (cnt_v[i]),
            .ack_q    (ack_v[i]),
            .pend_q   (chan_irq[i]),
            .pend_nxt (pend_nxt[i])
        );
    end

    irqack_readmux #(
        .N_CH (N_CH)
    ) u_readmux (
        .sel   (sel),
        .cnt_v (cnt_v),
        .ack_v (ack_v),
        .word  (rd_word)
    );

    always_comb begin
        top_d       = top_q;
        top_d.rdata = reg_rd_en ? rd_word : '0;
        top_d.any   = |pend_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign reg_rdata = top_q.rdata;
    assign any_irq   = top_q.any;
endmodule

// File: rtl/irqack_checker.sv
module irqack_checker #(
    parameter int N_CH   = 4,
    parameter int ADDR_W = 8,
    parameter int BASE   = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic              reg_rd_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_rdata,
    input logic [N_CH-1:0]   done_strobe,
    input logic [N_CH-1:0]   chan_irq,
    input logic              any_irq
);
    // R9: combined line follows the OR of channel lines
    a_r9_any_matches_or: assert property (@(posedge clk) disable iff (!rst_n)
        any_irq == (|chan_irq));

    // R3: reserved bits always read zero
    a_r3_rsvd_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[31:30] == 2'b00) && (reg_rdata[23:6] == 18'd0));

    // R2: no read request means zero read data next cycle
    a_r2_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_en |=> (reg_rdata == 32'd0));

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        logic wr_hit;
        assign wr_hit = reg_wr_en && (reg_addr == ADDR_W'(BASE + 4 * i));

        // R4: a strobe on an idle channel raises its interrupt
        a_r4_strobe_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
            (done_strobe[i] && !wr_hit && !chan_irq[i]) |=> chan_irq[i]);

        // R6: with no strobe and no write, the interrupt holds
        a_r6_irq_holds_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (!done_strobe[i] && !reg_wr_en) |=> $stable(chan_irq[i]));
    end
endmodule

bind irq_ack_tracker irqack_checker #(
    .N_CH   (N_CH),
    .ADDR_W (ADDR_W),
    .BASE   (BASE)
) u_irqack_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_rd_en   (reg_rd_en),
    .reg_addr    (reg_addr),
    .reg_rdata   (reg_rdata),
    .done_strobe (done_strobe),
    .chan_irq    (chan_irq),
    .any_irq     (any_irq)
);

// File: tb/irq_ack_tracker_bench.sv
module irq_ack_tracker_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N_CH       = 4;
    localparam int ADDR_W     = 8;
    localparam int BASE       = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr_en = 1'b0;
    logic              reg_rd_en = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [N_CH-1:0]   done_strobe = '0;
    logic [N_CH-1:0]   chan_irq;
    logic              any_irq;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_ack_tracker #(
        .N_CH   (N_CH),
        .ADDR_W (ADDR_W),
        .BASE   (BASE)
    ) u_irq_ack_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_en   (reg_wr_en),
        .reg_rd_en   (reg_rd_en),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .done_strobe (done_strobe),
        .chan_irq    (chan_irq),
        .any_irq     (any_irq)
    );

    typedef struct packed {
        logic        strobe;
        logic        wr;
        logic [31:0] wdata;
        logic [5:0]  cnt;
        logic [5:0]  ack;
        logic        irq;
    } vec_t;

    // channel 1 sequence; expected state after each step
    localparam vec_t VECS [8] = '{
        '{1'b1, 1'b0, 32'h0000_0000, 6'd1, 6'd0, 1'b1},  // R4
        '{1'b1, 1'b0, 32'h0000_0000, 6'd2, 6'd0, 1'b1},  // R4
        '{1'b0, 1'b1, 32'h0000_0001, 6'd2, 6'd1, 1'b1},  // R6 stale
        '{1'b0, 1'b1, 32'h0000_0002, 6'd2, 6'd2, 1'b0},  // R6 match
        '{1'b1, 1'b1, 32'h0000_0002, 6'd3, 6'd2, 1'b1},  // R7 collision
        '{1'b0, 1'b1, 32'hFFFF_FFC3, 6'd3, 6'd3, 1'b0},  // R8 R3 junk bits
        '{1'b1, 1'b0, 32'h0000_0000, 6'd4, 6'd3, 1'b1},  // R4
        '{1'b0, 1'b1, 32'h0000_0004, 6'd4, 6'd4, 1'b0}   // R6
    };

    function automatic logic [ADDR_W-1:0] ch_addr(input int ch);
        return ADDR_W'(BASE + 4 * ch);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // inputs set at a falling edge, held across one rising edge
    task automatic step(input logic [N_CH-1:0] strobe, input logic wr,
                        input logic [ADDR_W-1:0] addr, input logic [31:0] data);
        done_strobe = strobe;
        reg_wr_en   = wr;
        reg_addr    = addr;
        reg_wdata   = data;
        @(negedge clk);
        done_strobe = '0;
        reg_wr_en   = 1'b0;
        reg_wdata   = '0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] addr, output logic [31:0] v);
        reg_rd_en = 1'b1;
        reg_addr  = addr;
        @(negedge clk);
        v         = reg_rdata;
        reg_rd_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL all watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [N_CH-1:0] msk;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "chan_irq", 32'(chan_irq), 32'd0);
        chk("R1", "any_irq", 32'(any_irq), 32'd0);
        chk("R1", "rdata idle", reg_rdata, 32'd0);
        for (int c = 0; c < N_CH; c++) begin
            rd(ch_addr(c), v);
            chk("R1", "reg after reset", v, 32'd0);
        end

        // table walk on channel 1 (R2 R3 R4 R6 R7 R8)
        for (int k = 0; k < 8; k++) begin
            step(VECS[k].strobe ? 4'b0010 : 4'b0000, VECS[k].wr, ch_addr(1), VECS[k].wdata);
            chk("R6", "chan_irq[1]", 32'(chan_irq[1]), 32'(VECS[k].irq));
            chk("R9", "any_irq", 32'(any_irq), 32'(VECS[k].irq));
            rd(ch_addr(1), v);
            chk("R2", "ch1 word", v, {2'b00, VECS[k].cnt, 18'd0, VECS[k].ack});
        end

        // R11 other channels untouched by channel 1 activity
        rd(ch_addr(0), v);
        chk("R11", "ch0 word", v, 32'd0);
        rd(ch_addr(3), v);
        chk("R11", "ch3 word", v, 32'd0);

        // R9 combined interrupt with two channels
        step(4'b1000, 1'b0, '0, '0);
        chk("R9", "chan_irq ch3", 32'(chan_irq), 32'h8);
        chk("R9", "any ch3", 32'(any_irq), 32'd1);
        step(4'b1001, 1'b0, '0, '0);
        chk("R11", "chan_irq ch0+3", 32'(chan_irq), 32'h9);
        step(4'b0000, 1'b1, ch_addr(3), 32'd2);
        chk("R6", "chan_irq after ch3 ack", 32'(chan_irq), 32'h1);
        chk("R9", "any still set", 32'(any_irq), 32'd1);
        step(4'b0000, 1'b1, ch_addr(0), 32'd1);
        chk("R9", "any cleared", 32'(any_irq), 32'd0);
        chk("R6", "chan_irq all clear", 32'(chan_irq), 32'd0);

        // R10 writes to non-channel addresses
        step(4'b0000, 1'b1, ch_addr(N_CH), 32'd9);
        step(4'b0000, 1'b1, ADDR_W'(BASE + 1), 32'd5);
        step(4'b0000, 1'b1, ADDR_W'(BASE - 4), 32'd7);
        chk("R10", "chan_irq", 32'(chan_irq), 32'd0);
        rd(ch_addr(0), v);
        chk("R10", "ch0 word", v, {2'b00, 6'd1, 18'd0, 6'd1});
        rd(ch_addr(1), v);
        chk("R10", "ch1 word", v, {2'b00, 6'd4, 18'd0, 6'd4});
        rd(ch_addr(2), v);
        chk("R10", "ch2 word", v, 32'd0);
        rd(ch_addr(3), v);
        chk("R10", "ch3 word", v, {2'b00, 6'd2, 18'd0, 6'd2});
        rd(ch_addr(N_CH), v);
        chk("R2", "unmapped read", v, 32'd0);

        // R5 wrap on channel 2
        for (int k = 0; k < 63; k++) begin
            step(4'b0100, 1'b0, '0, '0);
        end
        rd(ch_addr(2), v);
        chk("R5", "ch2 at 63", v, {2'b00, 6'd63, 18'd0, 6'd0});
        chk("R4", "ch2 irq at 63", 32'(chan_irq[2]), 32'd1);
        step(4'b0100, 1'b0, '0, '0);
        msk = chan_irq;
        chk("R5", "ch2 irq after wrap", 32'(msk[2]), 32'd0);
        rd(ch_addr(2), v);
        chk("R5", "ch2 after wrap", v, 32'd0);

        // R2 read data returns to zero after the read
        @(negedge clk);
        chk("R2", "rdata after read", reg_rdata, 32'd0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule